// File: doc/BRIEF.md
# Fractional Prescaled Baud Generator

This block derives the two timing strobes a UART needs from its bus clock: a sample strobe at the oversampling rate and a bit strobe at the line rate. Three stages sit in series. A phase-accumulating prescaler thins the bus clock by the fractional factor (256 + MULT)/256. An integer stage then divides the prescaled enables by BRG + 1. An oversample stage divides the resulting sample strobes by OSR + 1. The full division, expressed in 1/256 units of a bus cycle, is (256 + MULT)·(BRG + 1)·(OSR + 1).

The divider settings are presented as level inputs. Any change to any of them restarts all three stages from their start values, so the first strobe after the change marks a whole new period. With the enable low, every stage is held at its start value and no strobe is issued.

Top module: `frac_baud_gen`

## Requirements
- R1: While reset is asserted and in the cycle after its release, `sample_tick_o` and `bit_tick_o` are 0.
- R2: Counting bus clock edges from the first counting edge, the j-th prescaled enable is produced on edge ceil(j·(256+MULT)/256). Here MULT is the 8-bit value on `mult_i`, from 0 to 255.
- R3: A sample strobe is issued one bus cycle after every (BRG+1)-th prescaled enable. BRG is the 16-bit value on `brg_i`, so the integer division runs from 1 to 65536. With BRG nonzero, two sample strobes are never on adjacent cycles.
- R4: The bit strobe is high exactly on every (OSR+1)-th sample strobe, in the same cycle as that sample strobe, and at no other time.
- R5: An `osr_i` value below 4 is treated as 4, so the bit strobe then falls on every 5th sample strobe.
- R6: A change on `mult_i`, `brg_i` or `osr_i` restarts all stages. Counting resumes on the next edge, the first sample strobe after the change is seen ceil((BRG+1)·(256+MULT)/256) + 2 cycles after the change, and no strobe appears in the cycle after the change.
- R7: While `en` is low, no strobe is issued. When `en` rises, the first sample strobe is seen ceil((BRG+1)·(256+MULT)/256) + 1 cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable; low holds all stages at their start values |
| mult_i | input | 8 | Fractional prescale numerator, divide by (256+MULT)/256 |
| brg_i | input | 16 | Integer divider setting, divide by BRG+1 |
| osr_i | input | 4 | Oversample setting, divide by OSR+1 (minimum 4) |
| sample_tick_o | output | 1 | One-cycle oversampling strobe |
| bit_tick_o | output | 1 | One-cycle bit strobe, coincident with a sample strobe |

## Verification
The bench stamps every strobe with its bus-cycle index from the moment a setting changes. It compares the index against the ceiling formula, so any error in the prescaler's carry handling shows as a strobe drifting one cycle early or late. The extreme ratios are each tried: MULT of 0 and 255 (every-cycle enables and near-halving), and BRG of 0 (a strobe on every enable) and 65535 (a counter one bit too narrow would fire far too early). Settings are changed part-way through a period to catch a design that keeps a stale phase and emits a short first period. Oversample settings below the minimum are applied; a design without the clamp would place the bit strobe on the wrong sample strobe.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
   // Fractional step of the prescaler: one bus cycle equals 2**FBG_FRAC_W units.
   localparam int FBG_FRAC_W  = 8;
   // Smallest oversample setting honoured by default.
   localparam int FBG_OSR_MIN = 4;

   // Clamp an oversample setting to a floor.
   function automatic int unsigned fbg_clamp(input int unsigned val, input int unsigned floor_v);
      return (val < floor_v) ? floor_v : val;
   endfunction
endpackage

// File: rtl/fbg_frac_prescaler.sv
module fbg_frac_prescaler #(
   parameter int MULT_W = fbg_pkg::FBG_FRAC_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart_i,
   input  logic [MULT_W-1:0] mult_i,
   output logic              pre_en_o
);
   localparam int ACC_W = MULT_W + 2;
   localparam logic [ACC_W-1:0] UNIT = ACC_W'(2 ** MULT_W);

   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] acc_sum;
   logic [ACC_W-1:0] modulus;

   assign modulus = UNIT + ACC_W'(mult_i);
   assign acc_sum = acc_q + UNIT;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q    <= '0;
         pre_en_o <= 1'b0;
      end else if (restart_i) begin
         acc_q    <= '0;
         pre_en_o <= 1'b0;
      end else if (acc_sum >= modulus) begin
         acc_q    <= acc_sum - modulus;
         pre_en_o <= 1'b1;
      end else begin
         acc_q    <= acc_sum;
         pre_en_o <= 1'b0;
      end
   end
endmodule

// File: rtl/fbg_int_divider.sv
module fbg_int_divider #(
   parameter int BRG_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart_i,
   input  logic             pre_en_i,
   input  logic [BRG_W-1:0] brg_i,
   output logic             sample_tick_o
);
   logic [BRG_W-1:0] cnt_q;
   logic             at_end;

   assign at_end = (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q         <= '0;
         sample_tick_o <= 1'b0;
      end else if (restart_i) begin
         cnt_q         <= brg_i;
         sample_tick_o <= 1'b0;
      end else if (pre_en_i) begin
         cnt_q         <= at_end ? brg_i : cnt_q - 1'b1;
         sample_tick_o <= at_end;
      end else begin
         sample_tick_o <= 1'b0;
      end
   end
endmodule

// File: rtl/fbg_os_counter.sv
module fbg_os_counter #(
   parameter int OSR_W   = 4,
   parameter int OSR_MIN = fbg_pkg::FBG_OSR_MIN
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart_i,
   input  logic             sample_tick_i,
   input  logic [OSR_W-1:0] osr_i,
   output logic             bit_tick_o
);
   logic [OSR_W-1:0] osr_eff;
   logic [OSR_W-1:0] cnt_q;
   logic             at_end;

   generate
      if (OSR_MIN > 0) begin : g_clamp
         assign osr_eff = OSR_W'(fbg_pkg::fbg_clamp(32'(osr_i), 32'(OSR_MIN)));
      end else begin : g_raw
         assign osr_eff = osr_i;
      end
   endgenerate

   assign at_end     = (cnt_q == osr_eff);
   assign bit_tick_o = sample_tick_i && at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart_i) begin
         cnt_q <= '0;
      end else if (sample_tick_i) begin
         cnt_q <= at_end ? '0 : cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
   parameter int MULT_W  = fbg_pkg::FBG_FRAC_W,
   parameter int BRG_W   = 16,
   parameter int OSR_W   = 4,
   parameter int OSR_MIN = fbg_pkg::FBG_OSR_MIN
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [MULT_W-1:0] mult_i,
   input  logic [BRG_W-1:0]  brg_i,
   input  logic [OSR_W-1:0]  osr_i,
   output logic              sample_tick_o,
   output logic              bit_tick_o
);
   localparam int CFG_W = MULT_W + BRG_W + OSR_W;

   generate
      if (MULT_W < 1 || BRG_W < 1 || OSR_W < 1) begin : g_bad_width
         $error("frac_baud_gen: every field width must be at least 1");
      end
      if (OSR_MIN >= 2 ** OSR_W) begin : g_bad_osr_min
         $error("frac_baud_gen: OSR_MIN does not fit in OSR_W bits");
      end
   endgenerate

   logic [CFG_W-1:0] cfg_now;
   logic [CFG_W-1:0] cfg_q;
   logic             restart;
   logic             pre_en;

   assign cfg_now = {mult_i, brg_i, osr_i};
   assign restart = !en || (cfg_now != cfg_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_q <= '0;
      else        cfg_q <= cfg_now;
   end

   fbg_frac_prescaler #(.MULT_W(MULT_W)) u_pre (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart_i (restart),
      .mult_i    (mult_i),
      .pre_en_o  (pre_en)
   );

   fbg_int_divider #(.BRG_W(BRG_W)) u_div (
      .clk           (clk),
      .rst_n         (rst_n),
      .restart_i     (restart),
      .pre_en_i      (pre_en),
      .brg_i         (brg_i),
      .sample_tick_o (sample_tick_o)
   );

   fbg_os_counter #(.OSR_W(OSR_W), .OSR_MIN(OSR_MIN)) u_os (
      .clk           (clk),
      .rst_n         (rst_n),
      .restart_i     (restart),
      .sample_tick_i (sample_tick_o),
      .osr_i         (osr_i),
      .bit_tick_o    (bit_tick_o)
   );
endmodule

// File: rtl/fbg_checker.sv
module fbg_checker #(
   parameter int MULT_W = 8,
   parameter int BRG_W  = 16,
   parameter int OSR_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              en,
   input logic [MULT_W-1:0] mult_i,
   input logic [BRG_W-1:0]  brg_i,
   input logic [OSR_W-1:0]  osr_i,
   input logic              sample_tick_o,
   input logic              bit_tick_o
);
   AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!sample_tick_o && !bit_tick_o)); // R7

   AST_BIT_WITH_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
      bit_tick_o |-> sample_tick_o); // R4

   AST_RELOAD_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      ({mult_i, brg_i, osr_i} != $past({mult_i, brg_i, osr_i})) |=> !sample_tick_o); // R6

   AST_SAMPLE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_tick_o && brg_i != '0) |=> !sample_tick_o); // R3
endmodule

bind frac_baud_gen fbg_checker #(.MULT_W(MULT_W), .BRG_W(BRG_W), .OSR_W(OSR_W)) u_fbg_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .en            (en),
   .mult_i        (mult_i),
   .brg_i         (brg_i),
   .osr_i         (osr_i),
   .sample_tick_o (sample_tick_o),
   .bit_tick_o    (bit_tick_o)
);

// File: tb/frac_baud_gen_tb_top.sv
module frac_baud_gen_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0;
   logic [7:0]  mult = '0;
   logic [15:0] brg = '0;
   logic [3:0]  osr = 4'd4;
   logic        sample_tick;
   logic        bit_tick;

   int n_checks = 0;
   int n_fails  = 0;
   int prev_m = -1, prev_b = -1, prev_o = -1;

   always #5 clk = ~clk;

   frac_baud_gen dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .en            (en),
      .mult_i        (mult),
      .brg_i         (brg),
      .osr_i         (osr),
      .sample_tick_o (sample_tick),
      .bit_tick_o    (bit_tick)
   );

   function automatic longint edge_of(longint j, longint modulus);
      return (j * modulus + 255) / 256;
   endfunction

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Apply a setting (through a change, or by raising en) and stamp nt sample strobes.
   task automatic run_cfg(input int m, input int b, input int o, input int nt, input bit via_en);
      int     oe  = (o < 4) ? 4 : o;
      longint md  = 256 + m;
      longint lat;
      longint cyc = 0;
      int     idx = 0;
      if (via_en) begin
         en = 1'b0;
         mult = 8'(m); brg = 16'(b); osr = 4'(o);
         repeat (3) @(negedge clk);
         en  = 1'b1;
         lat = 1;
      end else begin
         if (m == prev_m && b == prev_b && o == prev_o) b = b ^ 1;
         mult = 8'(m); brg = 16'(b); osr = 4'(o);
         lat = 2;
      end
      prev_m = m; prev_b = b; prev_o = o;
      while (idx < nt) begin
         @(negedge clk);
         cyc++;
         if (!via_en && cyc == 1)
            check(!sample_tick && !bit_tick, "R6 quiet after change", longint'(sample_tick), 0);
         if (bit_tick && !sample_tick)
            check(1'b0, "R4 bit strobe without sample", 1, 0);
         if (sample_tick) begin
            idx++;
            if (idx == 1)
               check(cyc == edge_of(b + 1, md) + lat, via_en ? "R7 first strobe" : "R6 first strobe",
                     cyc, edge_of(b + 1, md) + lat);
            else
               check(cyc == edge_of(longint'(idx) * (b + 1), md) + lat, "R2 R3 strobe position",
                     cyc, edge_of(longint'(idx) * (b + 1), md) + lat);
            check(bit_tick == ((idx % (oe + 1)) == 0), (o < 4) ? "R5 clamped bit strobe" : "R4 bit strobe",
                  longint'(bit_tick), longint'((idx % (oe + 1)) == 0));
         end
      end
   endtask

   task automatic idle_check(input int n);
      int seen = 0;
      en = 1'b0;
      repeat (n) begin
         @(negedge clk);
         if (sample_tick || bit_tick) seen++;
      end
      check(seen == 0, "R7 no strobe while disabled", seen, 0);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   endtask

   initial begin : main
      int m, b, o;
      void'($urandom(32'd5150));
      mult = 8'd17; brg = 16'd3; osr = 4'd6; en = 1'b1;
      repeat (4) begin
         @(negedge clk);
         check(!sample_tick && !bit_tick, "R1 quiet in reset", longint'(sample_tick | bit_tick), 0);
      end
      rst_n = 1'b1;
      @(negedge clk);
      check(!sample_tick && !bit_tick, "R1 quiet after release", longint'(sample_tick | bit_tick), 0);
      prev_m = 17; prev_b = 3; prev_o = 6;

      // Directed corners
      run_cfg(0,   0, 4, 12, 1'b0);   // every-cycle strobes
      run_cfg(255, 0, 7, 17, 1'b0);   // near-halving prescale
      run_cfg(128, 1, 5, 13, 1'b0);   // 1.5 prescale
      run_cfg(64,  2, 0, 11, 1'b0);   // osr 0 clamped
      run_cfg(200, 1, 3, 11, 1'b0);   // osr 3 clamped
      run_cfg(1,   5, 15, 17, 1'b0);  // largest oversample
      idle_check(300);
      run_cfg(77,  3, 9, 21, 1'b1);   // restart by enable
      repeat (5) @(negedge clk);
      run_cfg(0, 65535, 4, 1, 1'b0);  // widest integer division

      // Random settings, changed part-way through a period
      for (int it = 0; it < 18; it++) begin
         m = int'($urandom % 256);
         b = int'($urandom % 24);
         o = int'($urandom % 16);
         repeat (int'($urandom % 8)) @(negedge clk);
         run_cfg(m, b, o, 2 * (((o < 4) ? 4 : o) + 1) + 1, (it % 6) == 5);
      end
      idle_check(100);
      finish_run();
   end

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
      finish_run();
   end
endmodule